// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Control Sequencer

This block is the hardwired control unit of a small processor that works on a single accumulator. A two-bit cycle-code register records which part of the instruction cycle is running: fetch, indirect, execute or interrupt. A step counter advances once per clock inside each part. In every clock the block produces one micro-operation as a set of register-transfer enables for the address register, buffer register, program counter, instruction register and accumulator, together with memory read and write strobes. Each enable is a combinational function of the cycle code, the step, the one-hot decoded opcode and the status inputs.

The surrounding datapath owns the registers, the arithmetic unit and a memory with a one-cycle synchronous read. A read strobe in one step means the buffer register captures the data in the following step. The block takes the opcode and indirect bit from the instruction register, an interrupt request, the interrupt-enable flag and a zero flag that shows whether the buffer register holds zero.

Top module: `seqctl_top`

## Requirements
- R1: While reset is low and in the first cycle after reset, the cycle code is 00 (fetch) and the step count is 0, and only the address-from-PC enable is active.
- R2: Fetch runs five steps. Step 0: address register from PC. Step 1: memory read and PC increment. Step 2: buffer register from memory. Step 3: instruction register from buffer register. Step 4: no transfer.
- R3: The cycle code uses 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. The step count returns to 0 whenever the cycle code changes. At the end of fetch the code becomes 01 if ind_i is 1, and 10 otherwise.
- R4: Indirect runs four steps: address register from the instruction address field, memory read, buffer register from memory, and instruction address field from the buffer register. Execute follows.
- R5: Opcode 1 (add) executes as: address from the instruction field, memory read, buffer register from memory, then accumulator add.
- R6: Opcode 2 (increment and skip if zero) executes five steps: address from the instruction field, read, buffer load, buffer increment, then memory write. In that last step the PC is incremented only when zero_i is 1.
- R7: Opcode 3 (branch and save address) executes three steps. Step 0: address from the instruction field and buffer register from PC. Step 1: memory write and PC from the instruction field. Step 2: PC increment.
- R8: Any other opcode executes as a single step with no transfer.
- R9: At the end of execute with irq_i and ie_i both 1, the code becomes 11. Interrupt step 0 loads the address register from the save vector and the buffer register from PC. Interrupt step 1 writes memory, loads PC from the service vector and clears interrupt enable. Fetch follows.
- R10: With ie_i at 0, irq_i has no effect: execute is followed by fetch.
- R11: In any step at most one source drives each of the address register, the buffer register and the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opc_i | input | OPC_W (4) | Opcode from instruction register |
| ind_i | input | 1 | Indirect bit from instruction register |
| irq_i | input | 1 | Interrupt request |
| ie_i | input | 1 | Interrupt-enable flag |
| zero_i | input | 1 | Buffer register equals zero |
| cyc_o | output | 2 | Current cycle code |
| step_o | output | STEP_W (3) | Current step, 0 = first step |
| mar_pc_o | output | 1 | Address register from PC |
| mar_ir_o | output | 1 | Address register from instruction address field |
| mar_vec_o | output | 1 | Address register from interrupt save vector |
| mbr_mem_o | output | 1 | Buffer register from memory data |
| mbr_pc_o | output | 1 | Buffer register from PC |
| mbr_inc_o | output | 1 | Buffer register incremented |
| ir_load_o | output | 1 | Instruction register from buffer register |
| ir_addr_o | output | 1 | Instruction address field from buffer register |
| pc_inc_o | output | 1 | PC incremented |
| pc_ir_o | output | 1 | PC from instruction address field |
| pc_vec_o | output | 1 | PC from service routine vector |
| ac_add_o | output | 1 | Accumulator plus buffer register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| ie_clr_o | output | 1 | Clear interrupt enable |

## Verification
Every enable is combinational from the registered cycle code and step, so a micro-operation is due in the same clock as its step. The cycle-code and step outputs advance exactly one clock edge after the step they end. Branch decisions (indirect, skip, interrupt) use the inputs held during the final step of a sub-cycle, and take effect at the next edge. The bench's reference model keeps a queue of expected words, one per clock, and compares the outputs at each falling edge. It applies a new instruction's inputs only after the first fetch step has been compared, so no decision sees an input that changed early.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    // Sub-cycle encoding; the datapath decodes these values
    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_INDIR = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INTR  = 2'b11
    } cyc_e;

    // Positions in the one-hot opcode vector
    localparam int OP_ADD = 0;
    localparam int OP_ISZ = 1;
    localparam int OP_BSA = 2;
    localparam int N_OP   = 3;

    typedef struct packed {
        logic mar_pc;
        logic mar_ir;
        logic mar_vec;
        logic mbr_mem;
        logic mbr_pc;
        logic mbr_inc;
        logic ir_load;
        logic ir_addr;
        logic pc_inc;
        logic pc_ir;
        logic pc_vec;
        logic ac_add;
        logic mem_rd;
        logic mem_wr;
        logic ie_clr;
    } ctl_t;

endpackage

// File: rtl/seqctl_opdec.sv
module seqctl_opdec
    import seqctl_pkg::*;
#(
    parameter int OPC_W = 4,
    parameter logic [OPC_W-1:0] OPC_ADD = 4'd1,
    parameter logic [OPC_W-1:0] OPC_ISZ = 4'd2,
    parameter logic [OPC_W-1:0] OPC_BSA = 4'd3
) (
    input  logic [OPC_W-1:0] opc_i,
    output logic [N_OP-1:0]  hot_o
);
    localparam logic [OPC_W-1:0] CODE [N_OP] = '{OPC_ADD, OPC_ISZ, OPC_BSA};

    for (genvar g = 0; g < N_OP; g++) begin : g_dec
        assign hot_o[g] = (opc_i == CODE[g]);
    end

    // R8
    always_comb begin
        op_onehot_chk: assert ($onehot0(hot_o));
    end
endmodule

// File: rtl/seqctl_ucode.sv
module seqctl_ucode
    import seqctl_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  cyc_e              cyc_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [N_OP-1:0]   hot_i,
    input  logic              zero_i,
    output ctl_t              ctl_o,
    output logic              last_o
);
    always_comb begin
        ctl_o  = '0;
        last_o = 1'b0;
        unique case (cyc_i)
            CYC_FETCH: begin
                case (step_i)
                    STEP_W'(0): ctl_o.mar_pc = 1'b1;
                    STEP_W'(1): begin
                        ctl_o.mem_rd = 1'b1;
                        ctl_o.pc_inc = 1'b1;
                    end
                    STEP_W'(2): ctl_o.mbr_mem = 1'b1;
                    STEP_W'(3): ctl_o.ir_load = 1'b1;
                    default:    last_o = 1'b1;
                endcase
            end
            CYC_INDIR: begin
                case (step_i)
                    STEP_W'(0): ctl_o.mar_ir  = 1'b1;
                    STEP_W'(1): ctl_o.mem_rd  = 1'b1;
                    STEP_W'(2): ctl_o.mbr_mem = 1'b1;
                    default: begin
                        ctl_o.ir_addr = 1'b1;
                        last_o        = 1'b1;
                    end
                endcase
            end
            CYC_EXEC: begin
                if (hot_i[OP_ADD]) begin
                    case (step_i)
                        STEP_W'(0): ctl_o.mar_ir  = 1'b1;
                        STEP_W'(1): ctl_o.mem_rd  = 1'b1;
                        STEP_W'(2): ctl_o.mbr_mem = 1'b1;
                        default: begin
                            ctl_o.ac_add = 1'b1;
                            last_o       = 1'b1;
                        end
                    endcase
                end else if (hot_i[OP_ISZ]) begin
                    case (step_i)
                        STEP_W'(0): ctl_o.mar_ir  = 1'b1;
                        STEP_W'(1): ctl_o.mem_rd  = 1'b1;
                        STEP_W'(2): ctl_o.mbr_mem = 1'b1;
                        STEP_W'(3): ctl_o.mbr_inc = 1'b1;
                        default: begin
                            ctl_o.mem_wr = 1'b1;
                            ctl_o.pc_inc = zero_i;
                            last_o       = 1'b1;
                        end
                    endcase
                end else if (hot_i[OP_BSA]) begin
                    case (step_i)
                        STEP_W'(0): begin
                            ctl_o.mar_ir = 1'b1;
                            ctl_o.mbr_pc = 1'b1;
                        end
                        STEP_W'(1): begin
                            ctl_o.mem_wr = 1'b1;
                            ctl_o.pc_ir  = 1'b1;
                        end
                        default: begin
                            ctl_o.pc_inc = 1'b1;
                            last_o       = 1'b1;
                        end
                    endcase
                end else begin
                    last_o = 1'b1;
                end
            end
            CYC_INTR: begin
                case (step_i)
                    STEP_W'(0): begin
                        ctl_o.mar_vec = 1'b1;
                        ctl_o.mbr_pc  = 1'b1;
                    end
                    default: begin
                        ctl_o.mem_wr = 1'b1;
                        ctl_o.pc_vec = 1'b1;
                        ctl_o.ie_clr = 1'b1;
                        last_o       = 1'b1;
                    end
                endcase
            end
            default: last_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/seqctl_timer.sv
module seqctl_timer
    import seqctl_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_i,
    input  cyc_e              nxt_cyc_i,
    output cyc_e              cyc_o,
    output logic [STEP_W-1:0] step_o
);
    typedef struct packed {
        cyc_e              cyc;
        logic [STEP_W-1:0] step;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (last_i) begin
            st_d.cyc  = nxt_cyc_i;
            st_d.step = '0;
        end else begin
            st_d.step = st_q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cyc: CYC_FETCH, step: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_o  = st_q.cyc;
    assign step_o = st_q.step;
endmodule

// File: rtl/seqctl_top.sv
module seqctl_top
    import seqctl_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int STEP_W = 3,
    parameter logic [OPC_W-1:0] OPC_ADD = 4'd1,
    parameter logic [OPC_W-1:0] OPC_ISZ = 4'd2,
    parameter logic [OPC_W-1:0] OPC_BSA = 4'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opc_i,
    input  logic              ind_i,
    input  logic              irq_i,
    input  logic              ie_i,
    input  logic              zero_i,
    output logic [1:0]        cyc_o,
    output logic [STEP_W-1:0] step_o,
    output logic              mar_pc_o,
    output logic              mar_ir_o,
    output logic              mar_vec_o,
    output logic              mbr_mem_o,
    output logic              mbr_pc_o,
    output logic              mbr_inc_o,
    output logic              ir_load_o,
    output logic              ir_addr_o,
    output logic              pc_inc_o,
    output logic              pc_ir_o,
    output logic              pc_vec_o,
    output logic              ac_add_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              ie_clr_o
);
    logic [N_OP-1:0]   hot;
    cyc_e              cyc_q;
    logic [STEP_W-1:0] step_q;
    ctl_t              ctl;
    logic              last;
    cyc_e              nxt_cyc_d;

    seqctl_opdec #(
        .OPC_W  (OPC_W),
        .OPC_ADD(OPC_ADD),
        .OPC_ISZ(OPC_ISZ),
        .OPC_BSA(OPC_BSA)
    ) i_opdec (
        .opc_i(opc_i),
        .hot_o(hot)
    );

    seqctl_ucode #(.STEP_W(STEP_W)) i_ucode (
        .cyc_i (cyc_q),
        .step_i(step_q),
        .hot_i (hot),
        .zero_i(zero_i),
        .ctl_o (ctl),
        .last_o(last)
    );

    // Sub-cycle that follows the current one once its last step ends
    always_comb begin
        unique case (cyc_q)
            CYC_FETCH: nxt_cyc_d = ind_i ? CYC_INDIR : CYC_EXEC;
            CYC_INDIR: nxt_cyc_d = CYC_EXEC;
            CYC_EXEC:  nxt_cyc_d = (irq_i && ie_i) ? CYC_INTR : CYC_FETCH;
            default:   nxt_cyc_d = CYC_FETCH;
        endcase
    end

    seqctl_timer #(.STEP_W(STEP_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_i   (last),
        .nxt_cyc_i(nxt_cyc_d),
        .cyc_o    (cyc_q),
        .step_o   (step_q)
    );

    assign cyc_o     = cyc_q;
    assign step_o    = step_q;
    assign mar_pc_o  = ctl.mar_pc;
    assign mar_ir_o  = ctl.mar_ir;
    assign mar_vec_o = ctl.mar_vec;
    assign mbr_mem_o = ctl.mbr_mem;
    assign mbr_pc_o  = ctl.mbr_pc;
    assign mbr_inc_o = ctl.mbr_inc;
    assign ir_load_o = ctl.ir_load;
    assign ir_addr_o = ctl.ir_addr;
    assign pc_inc_o  = ctl.pc_inc;
    assign pc_ir_o   = ctl.pc_ir;
    assign pc_vec_o  = ctl.pc_vec;
    assign ac_add_o  = ctl.ac_add;
    assign mem_rd_o  = ctl.mem_rd;
    assign mem_wr_o  = ctl.mem_wr;
    assign ie_clr_o  = ctl.ie_clr;

    // R3
    step_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o != $past(cyc_o)) |-> (step_o == '0));

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> mbr_mem_o);

    // R4
    indir_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_addr_o |=> (cyc_o == 2'b10) && (step_o == '0));

    // R6
    skip_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o == 2'b10 && mem_wr_o && pc_inc_o) |-> zero_i);

    // R9
    ie_clr_in_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr_o |-> (cyc_o == 2'b11));

    // R11
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mar_pc_o, mar_ir_o, mar_vec_o}) &&
        $onehot0({mbr_mem_o, mbr_pc_o, mbr_inc_o}) &&
        $onehot0({pc_inc_o, pc_ir_o, pc_vec_o}));
endmodule

// File: tb/test_seqctl_top.sv
module test_seqctl_top;
    localparam int MARPC = 14, MARIR = 13, MARVEC = 12, MBRMEM = 11, MBRPC = 10;
    localparam int MBRINC = 9, IRLD = 8, IRADR = 7, PCINC = 6, PCIR = 5;
    localparam int PCVEC = 4, ACADD = 3, MRD = 2, MWR = 1, IECLR = 0;
    localparam int NPROG = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] opc = 4'd0;
    logic ind = 1'b0, irq = 1'b0, ie = 1'b0, zero = 1'b0;

    logic [1:0] cyc_o;
    logic [2:0] step_o;
    logic mar_pc_o, mar_ir_o, mar_vec_o, mbr_mem_o, mbr_pc_o, mbr_inc_o;
    logic ir_load_o, ir_addr_o, pc_inc_o, pc_ir_o, pc_vec_o, ac_add_o;
    logic mem_rd_o, mem_wr_o, ie_clr_o;

    always #5 clk = ~clk;

    seqctl_top i_seqctl_top (
        .clk(clk), .rst_n(rst_n), .opc_i(opc), .ind_i(ind), .irq_i(irq),
        .ie_i(ie), .zero_i(zero), .cyc_o(cyc_o), .step_o(step_o),
        .mar_pc_o(mar_pc_o), .mar_ir_o(mar_ir_o), .mar_vec_o(mar_vec_o),
        .mbr_mem_o(mbr_mem_o), .mbr_pc_o(mbr_pc_o), .mbr_inc_o(mbr_inc_o),
        .ir_load_o(ir_load_o), .ir_addr_o(ir_addr_o), .pc_inc_o(pc_inc_o),
        .pc_ir_o(pc_ir_o), .pc_vec_o(pc_vec_o), .ac_add_o(ac_add_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .ie_clr_o(ie_clr_o)
    );

    wire [14:0] ctl_w = {mar_pc_o, mar_ir_o, mar_vec_o, mbr_mem_o, mbr_pc_o,
                         mbr_inc_o, ir_load_o, ir_addr_o, pc_inc_o, pc_ir_o,
                         pc_vec_o, ac_add_o, mem_rd_o, mem_wr_o, ie_clr_o};

    // Program: opcode, indirect, irq, ie, zero (ADD=1, ISZ=2, BSA=3)
    logic [3:0] p_opc  [NPROG] = '{4'd1, 4'd1, 4'd2, 4'd2, 4'd2, 4'd3,
                                   4'd7, 4'd1, 4'd1, 4'd3, 4'd0, 4'd1};
    logic       p_ind  [NPROG] = '{0, 1, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0};
    logic       p_irq  [NPROG] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0};
    logic       p_ie   [NPROG] = '{0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 1, 0};
    logic       p_zero [NPROG] = '{0, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0, 1};

    logic [19:0] exp_q [$];
    string       tag_q [$];
    int checks = 0, errors = 0, idx = 0;
    bit running = 0, apply_pend = 0, finished = 0, reported = 0;

    function automatic logic [14:0] b(input int i);
        return 15'(1) << i;
    endfunction

    task automatic put(input logic [1:0] c, input int s, input logic [14:0] m,
                       input string t);
        exp_q.push_back({c, s[2:0], m});
        tag_q.push_back(t);
    endtask

    task automatic load(input logic [1:0] c);
        string te;
        case (c)
            2'b00: begin // R2
                put(2'b00, 0, b(MARPC), "R3/R2");
                put(2'b00, 1, b(MRD) | b(PCINC), "R2");
                put(2'b00, 2, b(MBRMEM), "R2");
                put(2'b00, 3, b(IRLD), "R2");
                put(2'b00, 4, '0, "R2");
            end
            2'b01: begin // R4
                put(2'b01, 0, b(MARIR), "R3/R4");
                put(2'b01, 1, b(MRD), "R4");
                put(2'b01, 2, b(MBRMEM), "R4");
                put(2'b01, 3, b(IRADR), "R4");
            end
            2'b10: begin
                te = (irq && ie) ? "R9" : (irq ? "R10" : "exec-end");
                case (opc)
                    4'd1: begin // R5
                        put(2'b10, 0, b(MARIR), "R3/R5");
                        put(2'b10, 1, b(MRD), "R5");
                        put(2'b10, 2, b(MBRMEM), "R5");
                        put(2'b10, 3, b(ACADD), {"R5/", te});
                    end
                    4'd2: begin // R6
                        put(2'b10, 0, b(MARIR), "R3/R6");
                        put(2'b10, 1, b(MRD), "R6");
                        put(2'b10, 2, b(MBRMEM), "R6");
                        put(2'b10, 3, b(MBRINC), "R6");
                        put(2'b10, 4, b(MWR) | (zero ? b(PCINC) : 15'd0), {"R6/", te});
                    end
                    4'd3: begin // R7
                        put(2'b10, 0, b(MARIR) | b(MBRPC), "R3/R7");
                        put(2'b10, 1, b(MWR) | b(PCIR), "R7");
                        put(2'b10, 2, b(PCINC), {"R7/", te});
                    end
                    default: put(2'b10, 0, '0, {"R8/", te}); // R8
                endcase
            end
            default: begin // R9
                put(2'b11, 0, b(MARVEC) | b(MBRPC), "R3/R9");
                put(2'b11, 1, b(MWR) | b(PCVEC) | b(IECLR), "R9");
            end
        endcase
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            logic [19:0] exp;
            logic [19:0] got;
            string tg;
            logic [1:0] cur, nxt;
            exp = exp_q.pop_front();
            tg  = tag_q.pop_front();
            got = {cyc_o, step_o, ctl_w};
            checks++;
            if (got !== exp) begin
                errors++;
                $display("FAIL %s: got cyc=%b step=%0d ctl=%b expected cyc=%b step=%0d ctl=%b",
                         tg, got[19:18], got[17:15], got[14:0],
                         exp[19:18], exp[17:15], exp[14:0]);
            end
            // R11: at most one source per destination register
            checks++;
            if (!($countones(ctl_w[14:12]) <= 1 &&
                  $countones({ctl_w[11:9]}) <= 1 &&
                  $countones({ctl_w[6:4]}) <= 1)) begin
                errors++;
                $display("FAIL R11: ctl=%b expected single source per register", ctl_w);
            end
            if (apply_pend) begin
                apply_pend = 0;
                opc  = p_opc[idx];
                ind  = p_ind[idx];
                irq  = p_irq[idx];
                ie   = p_ie[idx];
                zero = p_zero[idx];
                idx++;
            end
            if (exp_q.size() == 0) begin
                cur = exp[19:18];
                case (cur)
                    2'b00:   nxt = ind ? 2'b01 : 2'b10;     // R3
                    2'b01:   nxt = 2'b10;                   // R4
                    2'b10:   nxt = (irq && ie) ? 2'b11 : 2'b00; // R9, R10
                    default: nxt = 2'b00;
                endcase
                if (nxt == 2'b00) begin
                    if (idx >= NPROG) begin
                        running  = 0;
                        finished = 1;
                    end else begin
                        load(2'b00);
                        apply_pend = 1;
                    end
                end else begin
                    load(nxt);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (cyc_o !== 2'b00 || step_o !== 3'd0) begin
            errors++;
            $display("FAIL R1: got cyc=%b step=%0d expected cyc=00 step=0", cyc_o, step_o);
        end
        checks++;
        if (ctl_w !== b(MARPC)) begin
            errors++;
            $display("FAIL R1: got ctl=%b expected ctl=%b", ctl_w, b(MARPC));
        end
        load(2'b00);
        apply_pend = 1;
        @(posedge clk);
        #1;
        rst_n   = 1'b1;
        running = 1;
        wait (finished);
        @(negedge clk);
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got no completion expected program end");
        end
        summary();
    end
endmodule